// File: doc/BRIEF.md
# Streaming Sobel Edge Thresholder

This block turns a raster stream of 8-bit grayscale pixels into a stream of binary edge pixels, one output for every input, in the same raster order. Image width and height are fixed at elaboration time. Two line buffers hold the two rows above the current one, so that a 3x3 neighbourhood is available around every pixel of the row before the current one.

For each interior pixel the block forms a horizontal and a vertical gradient from that neighbourhood. It adds the squares of the two and writes 255 when that sum exceeds a threshold, or 0 when it does not. Pixels on the outer frame of the image are never evaluated and always come out as 0. The threshold is captured once per frame, when the pixel flagged as start-of-frame is accepted. Both stream edges use a valid/ready handshake. When the consumer holds off, the whole pipeline freezes.

The output runs one row plus one pixel behind the input. After the last pixel of a frame, the block emits the remaining row-and-a-pixel of outputs by itself and accepts no input while doing so. The width must be at least 4 and the height at least 3.

Top module: `sobel_edge_stream`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1 while out_ready is 1.
- R2: For an interior pixel with neighbourhood rows top/mid/bottom and columns left/centre/right, the horizontal gradient is (right column) minus (left column) and the vertical gradient is (top row) minus (bottom row). In both, the middle term of each line has weight 2 and the corner terms have weight 1.
- R3: An interior output is 255 when gx*gx + gy*gy is strictly greater than the captured threshold and 0 otherwise, so a sum equal to the threshold gives 0. No output other than 0 or 255 ever appears.
- R4: Every output pixel in row 0, row height-1, column 0 or column width-1 is 0, whatever the input.
- R5: Each frame produces exactly width*height outputs in raster order. Output number j of a frame (j < width*height - width - 1) is only presented after input number j + width + 1 of that frame has been accepted.
- R6: The last width+1 outputs of a frame are produced with no further input after the frame's last pixel.
- R7: The threshold used for a whole frame is the value on `thresh` in the cycle its start-of-frame pixel is accepted; later changes to `thresh` within the frame have no effect on it.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1, out_data does not change, and in_ready is 0.
- R9: The squared magnitude is carried at 21 bits unsigned, so sums above 2^20 (up to 2*1020*1020) compare correctly against any 21-bit threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | 21 | Magnitude threshold, captured on the start-of-frame pixel |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_data | input | 8 | Grayscale input pixel |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| out_valid | output | 1 | Output pixel present |
| out_data | output | 8 | Edge pixel, 255 or 0 |
| out_ready | input | 1 | Consumer takes the output pixel this cycle |

## Verification
The bench targets the exact threshold boundary, both for a plain vertical edge (sum 1040400) and for a diagonal edge whose sum of 1170450 exceeds 2^20. A strict/non-strict compare mix-up or a truncated magnitude would flip those pixels. Horizontal, vertical, ramp, flat and random images expose swapped weights, swapped line buffers and mis-sliced window columns, any of which scrambles interior pixels. A threshold change right after the start-of-frame pixel catches a design that compares against the live input. Random consumer stalls and input gaps catch lost, doubled or reordered pixels and input taken during a stall. The final frame must drain with no input behind it, which a design without its own end-of-frame flush cannot do.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  localparam int PIX_W  = 8;
  localparam int GRAD_W = PIX_W + 3;
  localparam int MAG_W  = 2 * GRAD_W - 1;

  typedef logic [PIX_W-1:0]               pix_t;
  typedef logic signed [GRAD_W-1:0]       grad_t;
  typedef logic [MAG_W-1:0]               mag_t;
  // index 0 = top row, 2 = bottom row
  typedef logic [2:0][PIX_W-1:0]          col_t;
  // [row][col], col 0 = oldest (left), col 2 = newest (right)
  typedef logic [2:0][2:0][PIX_W-1:0]     win_t;

  function automatic grad_t widen(pix_t p);
    return grad_t'({{(GRAD_W-PIX_W){1'b0}}, p});
  endfunction
endpackage

// File: rtl/sobel_linebuf.sv
module sobel_linebuf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single port, read-first: rdata returns the value stored before this write
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/sobel_window.sv
module sobel_window
  import sobel_pkg::*;
(
  input  logic clk,
  input  logic shift,
  input  col_t col_in,
  output win_t win
);
  for (genvar r = 0; r < 3; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (shift) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
        win[r][2] <= col_in[r];
      end
    end
  end
endmodule

// File: rtl/sobel_grad.sv
module sobel_grad
  import sobel_pkg::*;
(
  input  logic  clk,
  input  logic  en,
  input  win_t  win,
  output grad_t gx,
  output grad_t gy
);
  grad_t right_s, left_s, top_s, bot_s;

  always_comb begin
    right_s = widen(win[0][2]) + (widen(win[1][2]) << 1) + widen(win[2][2]);
    left_s  = widen(win[0][0]) + (widen(win[1][0]) << 1) + widen(win[2][0]);
    top_s   = widen(win[0][0]) + (widen(win[0][1]) << 1) + widen(win[0][2]);
    bot_s   = widen(win[2][0]) + (widen(win[2][1]) << 1) + widen(win[2][2]);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      gx <= right_s - left_s;
      gy <= top_s - bot_s;
    end
  end
endmodule

// File: rtl/sobel_mag.sv
module sobel_mag
  import sobel_pkg::*;
(
  input  logic  clk,
  input  logic  en,
  input  grad_t gx,
  input  grad_t gy,
  output mag_t  mag
);
  localparam int SQ_W = 2 * GRAD_W;

  logic signed [SQ_W-1:0] ex, ey, sx, sy;

  always_comb begin
    ex = SQ_W'(gx);
    ey = SQ_W'(gy);
    sx = ex * ex;
    sy = ey * ey;
  end

  always_ff @(posedge clk) begin
    if (en) mag <= mag_t'(sx + sy);
  end
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
  import sobel_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W-1:0] thresh,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  input  logic             out_ready
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam int FL_W  = $clog2(IMG_W + 1);
  localparam int NSTG  = 4;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);
  localparam logic [FL_W-1:0]  LAST_FL  = FL_W'(IMG_W);

  logic             adv, accept, flush_tok;
  logic             flushing;
  logic [FL_W-1:0]  fl_cnt;
  logic [COL_W-1:0] col_q, pos_c;
  logic [ROW_W-1:0] row_q, pos_r;
  mag_t             thr_q;
  logic             emit0, inter0;

  // one advance enable for every stage: the pipeline moves only when the
  // output slot is empty or being emptied
  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv && !flushing;
  assign accept    = in_valid && in_ready;
  assign flush_tok = adv && flushing;

  assign pos_c = in_sof ? '0 : col_q;
  assign pos_r = in_sof ? '0 : row_q;

  // interior centre sits one row up and one column left of the new pixel
  assign inter0 = accept && (pos_r >= ROW_W'(2)) && (pos_c >= COL_W'(2));
  assign emit0  = flush_tok ||
                  (accept && ((pos_r >= ROW_W'(2)) ||
                              ((pos_r == ROW_W'(1)) && (pos_c != '0))));

  // raster position and end-of-frame flush
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      row_q    <= '0;
      flushing <= 1'b0;
      fl_cnt   <= '0;
    end else if (accept) begin
      if (pos_c == LAST_COL) begin
        col_q <= '0;
        if (pos_r == LAST_ROW) begin
          row_q    <= '0;
          flushing <= 1'b1;
          fl_cnt   <= '0;
        end else begin
          row_q <= pos_r + ROW_W'(1);
        end
      end else begin
        col_q <= pos_c + COL_W'(1);
        row_q <= pos_r;
      end
    end else if (flush_tok) begin
      if (fl_cnt == LAST_FL) flushing <= 1'b0;
      else                   fl_cnt   <= fl_cnt + FL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  thr_q <= '0;
    else if (accept && in_sof) thr_q <= thresh;
  end

  // two row stores; the one holding row r-2 is overwritten by row r
  pix_t lb_q [2];
  for (genvar g = 0; g < 2; g++) begin : g_lb
    sobel_linebuf #(.DEPTH(IMG_W), .AW(COL_W), .DW(PIX_W)) u_lb (
      .clk   (clk),
      .en    (accept),
      .we    (pos_r[0] == 1'(g)),
      .addr  (pos_c),
      .wdata (in_data),
      .rdata (lb_q[g])
    );
  end

  // stage 1: column fetch
  logic s1_pix, s1_par;
  pix_t s1_bot;
  col_t col_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_pix <= 1'b0;
      s1_par <= 1'b0;
    end else if (adv) begin
      s1_pix <= accept;
      if (accept) s1_par <= pos_r[0];
    end
  end

  always_ff @(posedge clk) begin
    if (accept) s1_bot <= in_data;
  end

  always_comb begin
    col_s1[0] = s1_par ? lb_q[1] : lb_q[0];
    col_s1[1] = s1_par ? lb_q[0] : lb_q[1];
    col_s1[2] = s1_bot;
  end

  // stages 2..4: window, gradients, magnitude
  win_t  win;
  grad_t gx, gy;
  mag_t  mag;

  sobel_window u_win (
    .clk    (clk),
    .shift  (adv && s1_pix),
    .col_in (col_s1),
    .win    (win)
  );

  sobel_grad u_grad (
    .clk (clk),
    .en  (adv),
    .win (win),
    .gx  (gx),
    .gy  (gy)
  );

  sobel_mag u_mag (
    .clk (clk),
    .en  (adv),
    .gx  (gx),
    .gy  (gy),
    .mag (mag)
  );

  // token tags travel alongside the data, index 0 = stage 1
  logic [NSTG-1:0] emit_p, int_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      emit_p <= '0;
      int_p  <= '0;
    end else if (adv) begin
      emit_p <= {emit_p[NSTG-2:0], emit0};
      int_p  <= {int_p[NSTG-2:0], inter0};
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= emit_p[NSTG-1];
      out_data  <= (int_p[NSTG-1] && (mag > thr_q)) ? {PIX_W{1'b1}} : '0;
    end
  end
endmodule

// File: rtl/sobel_edge_checker.sv
module sobel_edge_checker #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  logic        rst_d;
  logic [31:0] acc_cnt, out_cnt;
  int          ocol, orow;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      acc_cnt <= '0;
      out_cnt <= '0;
      ocol    <= 0;
      orow    <= 0;
    end else begin
      if (in_valid && in_ready) acc_cnt <= acc_cnt + 32'd1;
      if (out_valid && out_ready) begin
        out_cnt <= out_cnt + 32'd1;
        if (ocol == IMG_W - 1) begin
          ocol <= 0;
          orow <= (orow == IMG_H - 1) ? 0 : orow + 1;
        end else begin
          ocol <= ocol + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_d && !rst)
      p_reset_r1: assert (!out_valid);
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_noaccept_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_binary_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == 8'd0 || out_data == 8'd255));

  p_border_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (orow == 0 || orow == IMG_H - 1 || ocol == 0 || ocol == IMG_W - 1))
      |-> (out_data == 8'd0));

  p_order_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> (acc_cnt > out_cnt));
endmodule

bind sobel_edge_stream sobel_edge_checker #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_sobel_edge_stream.sv
`timescale 1ns/1ps
module sim_sobel_edge_stream;
  localparam int W   = 6;
  localparam int H   = 5;
  localparam int TOT = W * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] thresh = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;

  always #5 clk = ~clk;

  sobel_edge_stream #(.IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst(rst), .thresh(thresh),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  int    checks = 0, failures = 0;
  int    exp_q[$];
  int    img[TOT];
  int    out_seen = 0, acc_done = 0, frames = 0, cyc = 0;
  bit    stall_en = 1'b0, running = 1'b0;
  bit    prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  string cur_tag = "R2";

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build(int kind);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (kind)
          0: img[r*W+c] = r * 40 + c * 10;
          1: img[r*W+c] = (c >= 3) ? 255 : 0;
          2: img[r*W+c] = (r >= 2) ? 255 : 0;
          3: img[r*W+c] = 200;
          4: img[r*W+c] = (c > r) ? 255 : 0;
          default: img[r*W+c] = int'($urandom % 256);
        endcase
  endtask

  function automatic int at(int r, int c);
    return img[r*W+c];
  endfunction

  task automatic push_expected(int thr);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int gx, gy, mag, e;
        e = 0;
        if (r > 0 && r < H-1 && c > 0 && c < W-1) begin
          gx = (at(r-1,c+1) + 2*at(r,c+1) + at(r+1,c+1))
             - (at(r-1,c-1) + 2*at(r,c-1) + at(r+1,c-1));
          gy = (at(r-1,c-1) + 2*at(r-1,c) + at(r-1,c+1))
             - (at(r+1,c-1) + 2*at(r+1,c) + at(r+1,c+1));
          mag = gx*gx + gy*gy;
          e = (mag > thr) ? 255 : 0;
        end
        exp_q.push_back(e);
      end
  endtask

  task automatic send_frame(int kind, int thr, int thr_after, bit gaps, string tag);
    build(kind);
    push_expected(thr);
    frames++;
    cur_tag = tag;
    thresh = 21'(thr);
    for (int k = 0; k < TOT; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_data  = 8'(img[k]);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_sof   = 1'b0;
      if (k == 0) thresh = 21'(thr_after);
    end
  endtask

  // consumer side
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // monitor, sampled between edges
  always @(negedge clk) begin
    if (running) begin
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
        chk(out_data == prev_data, "R8 data held", int'(out_data), int'(prev_data));
      end
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R8 no input in stall", int'(in_ready), 0);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        int l, r, c, e;
        l = out_seen % TOT;
        r = l / W;
        c = l % W;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 extra output", out_seen, frames * TOT);
        end else begin
          e = exp_q.pop_front();
          if (r == 0 || r == H-1 || c == 0 || c == W-1)
            chk(int'(out_data) == e, "R4 border", int'(out_data), e);
          else
            chk(int'(out_data) == e, cur_tag, int'(out_data), e);
        end
        if (l < TOT - W - 1)
          chk(acc_done >= out_seen + W + 2, "R5 lag", acc_done, out_seen + W + 2);
        else
          chk(acc_done >= (out_seen / TOT + 1) * TOT, "R5 lag end", acc_done,
              (out_seen / TOT + 1) * TOT);
        out_seen++;
      end
      if (in_valid && in_ready) acc_done++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R6 watchdog", out_seen, frames * TOT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    running = 1'b1;

    send_frame(0, 100, 100, 1'b0, "R2 ramp");
    send_frame(1, 1040399, 1040399, 1'b0, "R3 above");
    send_frame(1, 1040400, 1040400, 1'b0, "R3 equal");
    send_frame(2, 1040399, 1040399, 1'b0, "R2 vertical grad");
    send_frame(3, 0, 0, 1'b0, "R3 flat");
    send_frame(4, 1170449, 1170449, 1'b0, "R9 wide mag");
    send_frame(4, 1170450, 1170450, 1'b0, "R9 wide equal");
    send_frame(4, 2097151, 2097151, 1'b0, "R9 max thr");
    stall_en = 1'b1;
    for (int f = 0; f < 6; f++)
      send_frame(9, int'($urandom % 200000), int'($urandom % 200000), 1'b1, "R8 stalled");
    send_frame(9, 5000, 2097151, 1'b1, "R7 thr sampled");
    send_frame(4, 0, 2097151, 1'b0, "R7 thr sampled");
    stall_en = 1'b0;

    // R6: no further input; the last frame must still drain completely
    repeat (W * 4 + 40) @(posedge clk);
    @(negedge clk);
    chk(out_seen == frames * TOT, "R6 drained count", out_seen, frames * TOT);
    chk(exp_q.size() == 0, "R5 nothing missing", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R6 idle after drain", int'(out_valid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule